// File: doc/BRIEF.md
# Packet FIFO Interrupt and Control Register Block

This block is the software-visible control face of a packet FIFO bridge. A processor reaches it over a plain 32-bit register bus with address, write strobe, write data, read strobe and read data. Inside it keeps two registers. The first is a latched status register with one bit per event. The second is a mask that selects which of those events raise the single active-high interrupt line. The transmit and receive engines report events as one-cycle pulses. Each pulse is captured and stays captured until software clears it by writing a one.

The block also watches three dedicated addresses for a reset key. Writing the key to the transmit reset address or the receive reset address sends a one-cycle request to that engine. Writing it to the link reset address holds an external link reset output high for a fixed number of cycles. For that whole period, the status and mask registers are held at their power-up values. The FIFO data, length, vacancy and occupancy words belong to the datapath. This block returns zero for those words, and the bridge combines the read data outside.

Top module: `pkt_fifo_irq_regs`

## Requirements
- R1: After reset, the status word (offset 0x00) reads 0x01800000 and the enable word (offset 0x04) reads 0x01800000. `irq` is therefore high, and `tx_rst_req`, `rx_rst_req` and `link_rst` are low.
- R2: A pulse on `evt_pulse[k]` sets status bit k. Status bit k sits at register bit 31-k. The bit stays set after the pulse ends. The event order is:
  - 0: receive length read while empty
  - 1: receive read past the packet end
  - 2: receive data read while empty
  - 3: transmit write while full
  - 4: transmit done
  - 5: receive done
  - 6: transmit size mismatch
  - 7: transmit reset done
  - 8: receive reset done
- R3: Writing the status word clears every bit whose written bit is 1. Bits written 0 keep their value, and several bits may be cleared in one write.
- R4: If an event pulse and a clearing write hit the same status bit in one cycle, the bit stays set.
- R5: `irq` is high exactly when some status bit and the matching enable bit are both 1. It follows a register change in the same cycle the register updates.
- R6: The enable word is read/write in register bits 31..23 only. Bits 22..0 of both the status and the enable word read 0.
- R7: Writing exactly 0x000000A5 to offset 0x08 makes `tx_rst_req` high for the one cycle after the write. Any other value has no effect.
- R8: Writing exactly 0x000000A5 to offset 0x18 makes `rx_rst_req` high for the one cycle after the write. Any other value has no effect.
- R9: Writing exactly 0x000000A5 to offset 0x28 raises `link_rst` for LINK_RST_CYC cycles, starting the cycle after the write.
  - While `link_rst` is high, status and enable return to their R1 values.
  - Events, writes and further keys are ignored during that time.
- R10: Offsets 0x2C to 0x3C, the datapath offsets 0x0C, 0x10, 0x14, 0x1C, 0x20 and 0x24, and unaligned addresses all read 0. Writes to them change no register and no request.
- R11: `reg_rdata` shows the addressed word in the cycle after `reg_rd` is high, and is 0 in the cycle after `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the accessed word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| evt_pulse | input | 9 | Event pulses from the engines, order as in R2 |
| irq | output | 1 | Interrupt, active high |
| tx_rst_req | output | 1 | One-cycle transmit reset request |
| rx_rst_req | output | 1 | One-cycle receive reset request |
| link_rst | output | 1 | Link reset, held for LINK_RST_CYC cycles |

## Verification
A sticky bit that drops or fails to set appears at `irq` in the very next cycle whenever its enable is on. It also appears in any later read of the status word, because the captured state is never refreshed from the engines. A wrong enable bit shows the same way on `irq`. A bad key decode shows as a missing or stray request pulse exactly one cycle after the write. A wrong link timer shows as a `link_rst` window of the wrong length, or as registers that do not read their power-up values once the window closes.

// File: rtl/pfir_pkg.sv
package pfir_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned EVT_N = 9;
  localparam logic [REG_W-1:0] RESET_KEY = 32'h0000_00A5;

  // word index = byte offset / 4
  typedef enum logic [3:0] {
    WI_STATUS   = 4'd0,
    WI_ENABLE   = 4'd1,
    WI_TX_RST   = 4'd2,
    WI_TX_VAC   = 4'd3,
    WI_TX_DATA  = 4'd4,
    WI_TX_LEN   = 4'd5,
    WI_RX_RST   = 4'd6,
    WI_RX_OCC   = 4'd7,
    WI_RX_DATA  = 4'd8,
    WI_RX_LEN   = 4'd9,
    WI_LINK_RST = 4'd10
  } word_idx_e;

  // event positions (bit k of the event vector)
  localparam int unsigned EV_TX_RST_DONE = 7;
  localparam int unsigned EV_RX_RST_DONE = 8;

  function automatic logic [EVT_N-1:0] evt_default();
    logic [EVT_N-1:0] v;
    v = '0;
    v[EV_TX_RST_DONE] = 1'b1;
    v[EV_RX_RST_DONE] = 1'b1;
    return v;
  endfunction

  // event k lives at register bit REG_W-1-k
  function automatic logic [REG_W-1:0] evt_to_word(input logic [EVT_N-1:0] e);
    logic [REG_W-1:0] w;
    w = '0;
    for (int k = 0; k < EVT_N; k++) w[REG_W-1-k] = e[k];
    return w;
  endfunction

  function automatic logic [EVT_N-1:0] word_to_evt(input logic [REG_W-1:0] w);
    logic [EVT_N-1:0] e;
    for (int k = 0; k < EVT_N; k++) e[k] = w[REG_W-1-k];
    return e;
  endfunction

  function automatic logic key_match(input logic [REG_W-1:0] d);
    return d == RESET_KEY;
  endfunction

  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/pfir_addr_dec.sv
module pfir_addr_dec
  import pfir_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              sts_wr_o,
  output logic              en_wr_o,
  output logic              rd_sts_o,
  output logic              rd_en_o,
  output logic              link_start_o,
  output logic              tx_rst_req_o,
  output logic              rx_rst_req_o
);

  localparam int unsigned WIX_W = ADDR_W - 2;

  logic [WIX_W-1:0] widx;
  logic             aligned;
  logic             wr_ok;
  logic             key_ok;
  logic             tx_hit;
  logic             rx_hit;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_ok   = wr_i & ~busy_i & aligned;
  assign key_ok  = key_match(wdata_i);

  assign sts_wr_o     = wr_ok && (widx == WIX_W'(WI_STATUS));
  assign en_wr_o      = wr_ok && (widx == WIX_W'(WI_ENABLE));
  assign rd_sts_o     = aligned && (widx == WIX_W'(WI_STATUS));
  assign rd_en_o      = aligned && (widx == WIX_W'(WI_ENABLE));
  assign tx_hit       = wr_ok && key_ok && (widx == WIX_W'(WI_TX_RST));
  assign rx_hit       = wr_ok && key_ok && (widx == WIX_W'(WI_RX_RST));
  assign link_start_o = wr_ok && key_ok && (widx == WIX_W'(WI_LINK_RST));

  always_ff @(posedge clk) begin
    if (rst || busy_i) begin
      tx_rst_req_o <= 1'b0;
      rx_rst_req_o <= 1'b0;
    end else begin
      tx_rst_req_o <= tx_hit;
      rx_rst_req_o <= rx_hit;
    end
  end

  // R7: a transmit request follows only a keyed write to the transmit reset word
  p_tx_key_r7: assert property (@(posedge clk) disable iff (rst)
    tx_rst_req_o |-> $past(wr_i && !busy_i && addr_i == ADDR_W'(8) && wdata_i == 32'h0000_00A5));

  // R8: same for the receive side
  p_rx_key_r8: assert property (@(posedge clk) disable iff (rst)
    rx_rst_req_o |-> $past(wr_i && !busy_i && addr_i == ADDR_W'(24) && wdata_i == 32'h0000_00A5));

  // R10: writes to reserved words never produce a request
  p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i >= ADDR_W'(44)) |=> (!tx_rst_req_o && !rx_rst_req_o));

endmodule

// File: rtl/pfir_sticky.sv
module pfir_sticky
  import pfir_pkg::*;
#(
  parameter int unsigned        N   = EVT_N,
  parameter logic [N-1:0]       DEF = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_rst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || soft_rst_i) sts_o[k] <= DEF[k];
      else                   sts_o[k] <= sticky_next(sts_o[k], set_i[k], clr_i[k]);
    end

    // R2: a set bit without a clear stays set
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!soft_rst_i && sts_o[k] && !clr_i[k]) |=> sts_o[k]);

    // R4: an event wins over a same-cycle clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (!soft_rst_i && set_i[k]) |=> sts_o[k]);

    // R3: a clear without an event empties the bit
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (!soft_rst_i && clr_i[k] && !set_i[k]) |=> !sts_o[k]);
  end

endmodule

// File: rtl/pfir_link_timer.sv
module pfir_link_timer #(
  parameter int unsigned LINK_RST_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CNT_W = $clog2(LINK_RST_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
    else if (start_i)     cnt <= CNT_W'(LINK_RST_CYC);
  end

  assign busy_o = (cnt != '0);

  // R9: the window opens at its full length
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (cnt == CNT_W'(LINK_RST_CYC)));

  // R9: the window shrinks by one each cycle
  p_count_r9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pkt_fifo_irq_regs.sv
module pkt_fifo_irq_regs
  import pfir_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned LINK_RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  output logic              irq,
  output logic              tx_rst_req,
  output logic              rx_rst_req,
  output logic              link_rst
);

  localparam logic [EVT_N-1:0] EVT_DEF = evt_default();

  logic             sts_wr;
  logic             en_wr;
  logic             rd_sts;
  logic             rd_en;
  logic             link_start;
  logic             link_busy;
  logic [EVT_N-1:0] clr_v;
  logic [EVT_N-1:0] sts_q;
  logic [EVT_N-1:0] en_q;

  pfir_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (link_busy),
    .addr_i       (reg_addr),
    .wr_i         (reg_wr),
    .wdata_i      (reg_wdata),
    .sts_wr_o     (sts_wr),
    .en_wr_o      (en_wr),
    .rd_sts_o     (rd_sts),
    .rd_en_o      (rd_en),
    .link_start_o (link_start),
    .tx_rst_req_o (tx_rst_req),
    .rx_rst_req_o (rx_rst_req)
  );

  pfir_link_timer #(.LINK_RST_CYC(LINK_RST_CYC)) u_link (
    .clk     (clk),
    .rst     (rst),
    .start_i (link_start),
    .busy_o  (link_busy)
  );

  assign clr_v = sts_wr ? word_to_evt(reg_wdata) : '0;

  pfir_sticky #(.N(EVT_N), .DEF(EVT_DEF)) u_sts (
    .clk        (clk),
    .rst        (rst),
    .soft_rst_i (link_busy),
    .set_i      (evt_pulse),
    .clr_i      (clr_v),
    .sts_o      (sts_q)
  );

  always_ff @(posedge clk) begin
    if (rst || link_busy) en_q <= EVT_DEF;
    else if (en_wr)       en_q <= word_to_evt(reg_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst)                  reg_rdata <= '0;
    else if (reg_rd && rd_sts) reg_rdata <= evt_to_word(sts_q);
    else if (reg_rd && rd_en)  reg_rdata <= evt_to_word(en_q);
    else                       reg_rdata <= '0;
  end

  assign irq      = |(sts_q & en_q);
  assign link_rst = link_busy;

  // R11: an idle read strobe leaves zero on the read bus
  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd) |-> (reg_rdata == '0));

  // R5: with no event, write or link reset, a low interrupt stays low
  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!irq && evt_pulse == '0 && !reg_wr && !link_rst) |=> !irq);

  // R6: reserved bits of a read word are zero
  p_rsvd_bits_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-EVT_N-1:0] == '0);

  // R9: during the link reset window, no request leaves
  p_link_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(link_rst) |-> (!tx_rst_req && !rx_rst_req));

endmodule

// File: tb/pkt_fifo_irq_regs_tb_top.sv
module pkt_fifo_irq_regs_tb_top;

  localparam int TB_LINK = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [8:0]  evt_pulse = '0;
  logic        irq, tx_rst_req, rx_rst_req, link_rst;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // bench model
  logic [8:0] m_sts, m_en;
  int         m_cnt;
  localparam logic [8:0] M_DEF = 9'b1_1000_0000;

  always #10 clk = ~clk;

  pkt_fifo_irq_regs #(.ADDR_W(6), .LINK_RST_CYC(TB_LINK)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .irq(irq), .tx_rst_req(tx_rst_req),
    .rx_rst_req(rx_rst_req), .link_rst(link_rst)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] tb_pack(input logic [8:0] e);
    logic [31:0] w = '0;
    for (int b = 31; b >= 23; b--) w[b] = e[31-b];
    return w;
  endfunction

  function automatic logic [8:0] tb_unpack(input logic [31:0] w);
    logic [8:0] e;
    for (int b = 31; b >= 23; b--) e[31-b] = w[b];
    return e;
  endfunction

  function automatic logic [31:0] tb_read(input logic [5:0] a);
    if (a == 6'h00) return tb_pack(m_sts);
    if (a == 6'h04) return tb_pack(m_en);
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag, input logic [8:0] ev, input logic wr,
                      input logic [5:0] a, input logic [31:0] d, input logic rd);
    logic        busy, key, ok;
    logic [31:0] e_rd;
    logic        e_tx, e_rx;
    evt_pulse = ev; reg_wr = wr; reg_addr = a; reg_wdata = d; reg_rd = rd;
    busy = (m_cnt != 0);
    e_rd = rd ? tb_read(a) : 32'h0;
    ok   = wr && !busy;
    key  = ok && (d == 32'hA5);
    e_tx = key && (a == 6'h08);
    e_rx = key && (a == 6'h18);
    if (busy) begin
      m_sts = M_DEF; m_en = M_DEF; m_cnt--;
    end else begin
      logic [8:0] clr = (ok && a == 6'h00) ? tb_unpack(d) : 9'h0;
      m_sts = (m_sts & ~clr) | ev;
      if (ok && a == 6'h04) m_en = tb_unpack(d);
      if (key && a == 6'h28) m_cnt = TB_LINK;
    end
    @(posedge clk); #5;
    chk({tag, " rdata"}, reg_rdata, e_rd);
    chk("R5 irq", {31'h0, irq}, {31'h0, |(m_sts & m_en)});
    chk("R7 tx_rst_req", {31'h0, tx_rst_req}, {31'h0, e_tx});
    chk("R8 rx_rst_req", {31'h0, rx_rst_req}, {31'h0, e_rx});
    chk("R9 link_rst", {31'h0, link_rst}, {31'h0, m_cnt != 0});
  endtask

  initial begin : watchdog
    wait (cyc > 60000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5EED);
    m_sts = M_DEF; m_en = M_DEF; m_cnt = 0;
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {31'h0, irq}, 32'h1);
    tick("R1 status", 9'h0, 0, 6'h00, 0, 1);
    chk("R1 status value", reg_rdata, 32'h0180_0000);
    tick("R1 enable", 9'h0, 0, 6'h04, 0, 1);
    chk("R1 enable value", reg_rdata, 32'h0180_0000);

    // R3 clear both reset-complete bits, then a zero write
    tick("R3 w1c", 9'h0, 1, 6'h00, 32'h0180_0000, 0);
    chk("R3 irq off", {31'h0, irq}, 32'h0);
    tick("R3 zero write", 9'h010, 0, 6'h00, 0, 0);      // R2 transmit done
    tick("R3 zero write", 9'h0, 1, 6'h00, 32'h0, 0);
    tick("R2 sticky", 9'h0, 0, 6'h00, 0, 1);
    chk("R2 bit27", reg_rdata, 32'h0800_0000);

    // R6 enable masking
    tick("R6 enable wr", 9'h0, 1, 6'h04, 32'hFFFF_FFFF, 0);
    tick("R6 enable rd", 9'h0, 0, 6'h04, 0, 1);
    chk("R6 enable bits", reg_rdata, 32'hFF80_0000);

    // R4 set beats clear
    tick("R4 set+clr", 9'h001, 1, 6'h00, 32'h8800_0000, 0);
    tick("R4 readback", 9'h0, 0, 6'h00, 0, 1);
    chk("R4 bit31 kept", reg_rdata, 32'h8000_0000);

    // R7 / R8 keys
    tick("R7 key", 9'h0, 1, 6'h08, 32'hA5, 0);
    tick("R7 after", 9'h0, 0, 6'h00, 0, 0);
    tick("R7 bad", 9'h0, 1, 6'h08, 32'hA6, 0);
    tick("R7 bad2", 9'h0, 1, 6'h08, 32'h1A5, 0);
    tick("R8 key", 9'h0, 1, 6'h18, 32'hA5, 0);
    tick("R8 bad", 9'h0, 1, 6'h18, 32'hA500_0000, 0);
    tick("R8 after", 9'h0, 0, 6'h00, 0, 0);

    // R10 reserved and datapath words
    tick("R10 wr 2C", 9'h0, 1, 6'h2C, 32'hFFFF_FFFF, 0);
    tick("R10 wr 3C", 9'h0, 1, 6'h3C, 32'hFFFF_FFFF, 0);
    tick("R10 wr 10", 9'h0, 1, 6'h10, 32'hFFFF_FFFF, 0);
    tick("R10 wr unaligned", 9'h0, 1, 6'h01, 32'hFFFF_FFFF, 0);
    tick("R10 rd 30", 9'h0, 0, 6'h30, 0, 1);
    tick("R10 rd 1C", 9'h0, 0, 6'h1C, 0, 1);
    tick("R10 status kept", 9'h0, 0, 6'h00, 0, 1);
    chk("R10 status value", reg_rdata, 32'h8000_0000);

    // R9 link reset
    tick("R9 key", 9'h0, 1, 6'h28, 32'hA5, 0);
    for (int i = 0; i < TB_LINK; i++) tick("R9 window", 9'h1FF, 1, 6'h08, 32'hA5, 0);
    tick("R9 status default", 9'h0, 0, 6'h00, 0, 1);
    chk("R9 status value", reg_rdata, 32'h0180_0000);
    tick("R9 enable default", 9'h0, 0, 6'h04, 0, 1);
    chk("R9 enable value", reg_rdata, 32'h0180_0000);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      logic [8:0]  ev = 9'($urandom() & $urandom() & $urandom());
      logic [31:0] d = $urandom();
      logic [5:0]  a;
      if (d == 32'hA5) d = 32'hA4;
      case (op)
        0, 1, 2: tick("R3 rand", ev, 1, 6'h00, d, 0);
        3, 4:    tick("R6 rand", ev, 1, 6'h04, d, 0);
        5: begin
          a = 6'($urandom_range(11, 15) * 4);
          if ($urandom_range(0, 1) == 1) a = 6'h14;
          tick("R10 rand", ev, 1, a, d, 0);
        end
        6, 7: begin
          a = 6'($urandom_range(0, 15) * 4);
          tick("R11 rand", ev, 0, a, 0, 1);
        end
        default: begin
          if (i == 1500) tick("R9 rand", ev, 1, 6'h28, 32'hA5, 0);
          else           tick("R2 rand", ev, 0, 6'h00, 0, 0);
        end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule